// File: doc/BRIEF.md
# Multicycle Register-Transfer Processor Core

This core executes a five-instruction integer subset by breaking each instruction into short steps and doing one step per clock. The steps are fetch, decode with operand read, execute, an optional memory step and write-back. Each step ends in its own separately enabled register: the instruction word, two operand latches, an equality flag, the ALU result and the loaded memory word. A step controller walks through these steps. Register add and subtract, OR with an immediate, and store take four cycles. Load takes five cycles and branch-if-equal takes three.

The core has its own instruction port and its own data port. Both are word-wide and use combinational read timing: the memory must return the word for the address on the port within the same cycle. A data write happens at the clock edge that ends the cycle in which the write strobe is high. The register file holds 32 words of 32 bits. The program counter changes only at the end of the last step of an instruction, and it is the address shown on the instruction port.

Top module: `mc_core`

## Requirements
- R1: While `rst_n` is low, the program counter (`imem_addr`) is zero and neither data strobe is high. After release, the first instruction is fetched from address 0.
- R2: The R-type instructions (opcode 0x00) with funct 0x21 (add) and 0x23 (subtract) write rs+rt or rs-rt, modulo 2^32, into register rd. They complete in 4 cycles.
- R3: OR-immediate (opcode 0x0D) writes rs OR the zero-extended bits [15:0] into register rt. It completes in 4 cycles.
- R4: Load (opcode 0x23) reads data memory at rs plus the sign-extended bits [15:0], with `dmem_re` high only in its 4th cycle, and writes that word into rt. It completes in 5 cycles.
- R5: Store (opcode 0x2B) drives `dmem_we` for exactly its 4th cycle, with address rs plus the sign-extended bits [15:0] and with data equal to register rt. It completes in 4 cycles.
- R6: Branch-if-equal (opcode 0x04) completes in 3 cycles. The next PC is PC+4+(sext(imm16)<<2) when rs equals rt, and PC+4 otherwise.
- R7: The PC holds its value for the whole instruction and changes only at the end of the last cycle. For every non-branch instruction it becomes PC+4. It stays word-aligned.
- R8: Register 0 always reads as zero, and writes that target it have no effect.
- R9: Any other opcode, and an R-type instruction with any other funct, completes in 3 cycles. It sets PC to PC+4 and writes neither the register file nor memory.
- R10: `dmem_we` and `dmem_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Instruction address (program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Data address (ALU result register) |
| dmem_wdata | output | 32 | Store data (B operand register) |
| dmem_re | output | 1 | Data read strobe, load memory step |
| dmem_we | output | 1 | Data write strobe, store memory step |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, same cycle |

## Verification
The assertions check, on every cycle, the rules that can be seen on the memory strobes and the PC alone. They check that the strobes never overlap and that a write strobe lasts one cycle and is followed by PC+4. They check that a read strobe lasts one cycle and leaves the PC unchanged, that two PC updates are never in adjacent cycles, and that the PC is zero in reset. Arithmetic results, immediate extension, branch targets, exact cycle counts for each instruction, the behaviour of register zero and the handling of unsupported encodings can only be shown by running programs. The bench does this by running directed and random programs in lockstep with an instruction-level reference model. It compares every PC update, every store and the final memory image against that model.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] FN_ADDU   = 6'h21;
  localparam logic [5:0] FN_SUBU   = 6'h23;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE,
    ST_EX_RR, ST_WB_RR,
    ST_EX_ORI, ST_WB_ORI,
    ST_EX_LD, ST_MEM_LD, ST_WB_LD,
    ST_EX_ST, ST_MEM_ST,
    ST_BRANCH, ST_SKIP
  } step_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} alu_fn_e;
  typedef enum logic [1:0] {OPB_REG, OPB_ZEXT, OPB_SEXT} opb_sel_e;

  typedef struct packed {
    logic     ir_en;
    logic     ab_en;
    logic     s_en;
    logic     m_en;
    logic     rf_we;
    logic     wr_rd;
    logic     wr_mem;
    logic     pc_en;
    logic     pc_br;
    logic     dm_we;
    logic     dm_re;
    alu_fn_e  alu_fn;
    opb_sel_e opb;
  } ctl_t;

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  logic [N-1:0][W-1:0] words;

  for (genvar g = 0; g < N; g++) begin : g_word
    if (g == 0) begin : g_zero
      assign words[g] = '0;
    end else begin : g_store
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
        if (we && (waddr == AW'(g))) begin
          q <= wdata;
        end
      end
      assign words[g] = q;
    end
  end

  assign rdata_a = words[raddr_a];
  assign rdata_b = words[raddr_b];

endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y
);

  always_comb begin
    case (fn)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctl_t       ctl
);

  step_e step_q, step_d;
  logic  rr_ok;

  assign rr_ok = (funct == FN_ADDU) || (funct == FN_SUBU);

  always_comb begin
    step_d = ST_FETCH;
    case (step_q)
      ST_FETCH:  step_d = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OPC_RTYPE: step_d = rr_ok ? ST_EX_RR : ST_SKIP;
          OPC_ORI:   step_d = ST_EX_ORI;
          OPC_LW:    step_d = ST_EX_LD;
          OPC_SW:    step_d = ST_EX_ST;
          OPC_BEQ:   step_d = ST_BRANCH;
          default:   step_d = ST_SKIP;
        endcase
      end
      ST_EX_RR:  step_d = ST_WB_RR;
      ST_EX_ORI: step_d = ST_WB_ORI;
      ST_EX_LD:  step_d = ST_MEM_LD;
      ST_MEM_LD: step_d = ST_WB_LD;
      ST_EX_ST:  step_d = ST_MEM_ST;
      default:   step_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_FETCH;
    end else begin
      step_q <= step_d;
    end
  end

  always_comb begin
    ctl        = '0;
    ctl.alu_fn = ALU_ADD;
    ctl.opb    = OPB_REG;
    case (step_q)
      ST_FETCH:  ctl.ir_en = 1'b1;
      ST_DECODE: ctl.ab_en = 1'b1;
      ST_EX_RR: begin
        ctl.s_en   = 1'b1;
        ctl.alu_fn = (funct == FN_SUBU) ? ALU_SUB : ALU_ADD;
      end
      ST_WB_RR: begin
        ctl.rf_we = 1'b1;
        ctl.wr_rd = 1'b1;
        ctl.pc_en = 1'b1;
      end
      ST_EX_ORI: begin
        ctl.s_en   = 1'b1;
        ctl.alu_fn = ALU_OR;
        ctl.opb    = OPB_ZEXT;
      end
      ST_WB_ORI: begin
        ctl.rf_we = 1'b1;
        ctl.pc_en = 1'b1;
      end
      ST_EX_LD, ST_EX_ST: begin
        ctl.s_en = 1'b1;
        ctl.opb  = OPB_SEXT;
      end
      ST_MEM_LD: begin
        ctl.m_en  = 1'b1;
        ctl.dm_re = 1'b1;
      end
      ST_WB_LD: begin
        ctl.rf_we  = 1'b1;
        ctl.wr_mem = 1'b1;
        ctl.pc_en  = 1'b1;
      end
      ST_MEM_ST: begin
        ctl.dm_we = 1'b1;
        ctl.pc_en = 1'b1;
      end
      ST_BRANCH: begin
        ctl.pc_en = 1'b1;
        ctl.pc_br = 1'b1;
      end
      ST_SKIP:   ctl.pc_en = 1'b1;
      default:   ;
    endcase
  end

endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_re,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);

  ctl_t ctl;

  logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target;
  logic [31:0]     ir_q;
  logic [XLEN-1:0] a_q, b_q, s_q, m_q;
  logic            e_q;

  logic [RAW-1:0]  rs_idx, rt_idx, rd_idx, wr_idx;
  logic [15:0]     imm16;
  logic [XLEN-1:0] imm_zx, imm_sx, opb, alu_y;
  logic [XLEN-1:0] rf_a, rf_b, rf_wdata;

  assign rs_idx = RAW'(ir_q[25:21]);
  assign rt_idx = RAW'(ir_q[20:16]);
  assign rd_idx = RAW'(ir_q[15:11]);
  assign imm16  = ir_q[15:0];
  assign imm_zx = {{(XLEN-16){1'b0}}, imm16};
  assign imm_sx = {{(XLEN-16){imm16[15]}}, imm16};

  mc_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (ir_q[31:26]),
    .funct  (ir_q[5:0]),
    .ctl    (ctl)
  );

  assign wr_idx   = ctl.wr_rd  ? rd_idx : rt_idx;
  assign rf_wdata = ctl.wr_mem ? m_q    : s_q;

  mc_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk     (clk),
    .we      (ctl.rf_we),
    .waddr   (wr_idx),
    .wdata   (rf_wdata),
    .raddr_a (rs_idx),
    .raddr_b (rt_idx),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  always_comb begin
    case (ctl.opb)
      OPB_ZEXT: opb = imm_zx;
      OPB_SEXT: opb = imm_sx;
      default:  opb = b_q;
    endcase
  end

  mc_alu #(.W(XLEN)) u_alu (
    .a  (a_q),
    .b  (opb),
    .fn (ctl.alu_fn),
    .y  (alu_y)
  );

  assign pc_plus4  = pc_q + XLEN'(4);
  assign br_target = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
  assign pc_next   = (ctl.pc_br && e_q) ? br_target : pc_plus4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (ctl.pc_en) begin
      pc_q <= pc_next;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.ir_en) begin
      ir_q <= imem_rdata;
    end
    if (ctl.ab_en) begin
      a_q <= rf_a;
      b_q <= rf_b;
      e_q <= (rf_a == rf_b);
    end
    if (ctl.s_en) begin
      s_q <= alu_y;
    end
    if (ctl.m_en) begin
      m_q <= dmem_rdata;
    end
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = s_q;
  assign dmem_wdata = b_q;
  assign dmem_we    = ctl.dm_we;
  assign dmem_re    = ctl.dm_re;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] imem_addr,
  input logic            dmem_we,
  input logic            dmem_re
);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_state_r1: assert (imem_addr == '0 && !dmem_we && !dmem_re)
        else $error("reset state violated");
    end
  end

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_we && dmem_re));

  p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |=> !dmem_we);

  p_store_pc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |=> (imem_addr == $past(imem_addr) + XLEN'(4)));

  p_load_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_re |=> (!dmem_re && $stable(imem_addr)));

  p_pc_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_addr != $past(imem_addr)) |=> $stable(imem_addr));

  p_pc_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    imem_addr[1:0] == 2'b00);

endmodule

bind mc_core mc_core_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .imem_addr (imem_addr),
  .dmem_we   (dmem_we),
  .dmem_re   (dmem_re)
);

// File: tb/mc_core_tb.sv
`timescale 1ns/1ps
module mc_core_tb;
  import mc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_re, dmem_we;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic [31:0] ref_dmem [64];
  logic [31:0] ref_regs [32];
  logic [31:0] ref_pc;
  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  mc_core u_dut (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_re(dmem_re), .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {OPC_RTYPE, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic string tag_of(input logic [31:0] ins);
    case (ins[31:26])
      OPC_RTYPE: return (ins[5:0] == FN_ADDU || ins[5:0] == FN_SUBU) ? "R2" : "R9";
      OPC_ORI:   return "R3";
      OPC_LW:    return "R4";
      OPC_SW:    return "R5";
      OPC_BEQ:   return "R6";
      default:   return "R9";
    endcase
  endfunction

  function automatic logic [31:0] eff_addr(input logic [31:0] ins);
    return ref_regs[ins[25:21]] + {{16{ins[15]}}, ins[15:0]};
  endfunction

  task automatic ref_wr(input logic [4:0] idx, input logic [31:0] val);
    if (idx != 5'd0) ref_regs[idx] = val;
  endtask

  task automatic ref_exec(input logic [31:0] ins, output int cpi);
    logic [31:0] a, b, sx, ea, nxt;
    a   = ref_regs[ins[25:21]];
    b   = ref_regs[ins[20:16]];
    sx  = {{16{ins[15]}}, ins[15:0]};
    ea  = a + sx;
    nxt = ref_pc + 32'd4;
    cpi = 3;
    case (ins[31:26])
      OPC_RTYPE: begin
        if (ins[5:0] == FN_ADDU) begin ref_wr(ins[15:11], a + b); cpi = 4; end
        else if (ins[5:0] == FN_SUBU) begin ref_wr(ins[15:11], a - b); cpi = 4; end
      end
      OPC_ORI: begin ref_wr(ins[20:16], a | {16'h0, ins[15:0]}); cpi = 4; end
      OPC_LW:  begin ref_wr(ins[20:16], ref_dmem[ea[7:2]]); cpi = 5; end
      OPC_SW:  begin ref_dmem[ea[7:2]] = b; cpi = 4; end
      OPC_BEQ: if (a == b) nxt = nxt + {sx[29:0], 2'b00};
      default: ;
    endcase
    ref_pc = nxt;
  endtask

  task automatic build_program();
    logic [4:0] rs, rt, rd;
    int off;
    imem[0]  = enc_i(OPC_ORI, 5'd0, 5'd0, 16'h1234);          // R8 write to r0
    imem[1]  = enc_i(OPC_SW, 5'd0, 5'd0, 16'h0040);            // R8 r0 reads zero
    for (int k = 1; k < 16; k++)
      imem[1+k] = enc_i(OPC_ORI, 5'd0, 5'(k), 16'($urandom) | 16'h0001);
    imem[17] = enc_r(5'd1, 5'd2, 5'd0, FN_ADDU);               // R8 rd=0
    imem[18] = enc_i(OPC_SW, 5'd0, 5'd0, 16'h0044);
    imem[19] = enc_r(5'd0, 5'd1, 5'd6, FN_SUBU);               // R2 wrap
    imem[20] = enc_i(OPC_SW, 5'd0, 5'd6, 16'h0048);
    imem[21] = enc_r(5'd1, 5'd2, 5'd7, FN_ADDU);
    imem[22] = enc_i(OPC_SW, 5'd0, 5'd7, 16'h004C);
    imem[23] = enc_i(OPC_LW, 5'd0, 5'd8, 16'h0048);            // R4
    imem[24] = enc_i(OPC_SW, 5'd0, 5'd8, 16'h0050);
    imem[25] = enc_i(OPC_ORI, 5'd3, 5'd9, 16'h8001);           // R3 zero-extend
    imem[26] = enc_i(OPC_SW, 5'd0, 5'd9, 16'h0054);
    imem[27] = enc_i(OPC_BEQ, 5'd2, 5'd2, 16'h0001);           // R6 taken
    imem[28] = enc_i(OPC_ORI, 5'd0, 5'd10, 16'hBAD0);
    imem[29] = enc_i(OPC_BEQ, 5'd1, 5'd0, 16'h0001);           // R6 not taken
    imem[30] = enc_i(OPC_SW, 5'd0, 5'd10, 16'h0058);
    imem[31] = {6'h02, 26'h0000123};                           // R9 opcode
    imem[32] = enc_r(5'd1, 5'd2, 5'd3, 6'h20);                 // R9 funct
    imem[33] = enc_i(OPC_ORI, 5'd0, 5'd12, 16'h0060);
    imem[34] = enc_i(OPC_LW, 5'd12, 5'd11, 16'hFFFC);          // R4 negative offset
    imem[35] = enc_i(OPC_SW, 5'd12, 5'd11, 16'hFFF8);
    for (int i = 36; i < 64; i++) begin
      rs = 5'($urandom % 16);
      rt = 5'($urandom % 16);
      rd = 5'($urandom % 16);
      case ($urandom % 8)
        0: imem[i] = enc_r(rs, rt, rd, FN_ADDU);
        1: imem[i] = enc_r(rs, rt, rd, FN_SUBU);
        2: imem[i] = enc_i(OPC_ORI, rs, rt, 16'($urandom));
        3: imem[i] = enc_i(OPC_LW, rs, rt, 16'($urandom));
        4, 5: imem[i] = enc_i(OPC_SW, rs, rt, 16'($urandom));
        6: begin
          if ($urandom % 4 == 0) begin
            imem[i] = enc_i(OPC_BEQ, rs, rs, 16'(1 + $urandom % 4));
          end else begin
            off = int'($urandom % 11) - 4;
            if (off == -1) off = 1;
            imem[i] = enc_i(OPC_BEQ, rs, rs ^ 5'(1 + $urandom % 15), 16'(off));
          end
        end
        default: imem[i] = enc_i(6'h08, rs, rt, 16'($urandom));
      endcase
    end
  endtask

  initial begin
    logic [31:0] ins, ea;
    logic [31:0] last_pc;
    string tag;
    int cnt, cpi, done, cyc;
    bit hung;
    rst_n = 1'b0;
    void'($urandom(32'h5EED0042));
    build_program();
    for (int i = 0; i < 64; i++) begin
      dmem[i] = $urandom;
      ref_dmem[i] = dmem[i];
    end
    for (int i = 0; i < 32; i++) ref_regs[i] = '0;
    ref_pc = '0;

    repeat (3) @(negedge clk);
    chk(imem_addr == 32'h0, "R1 reset PC", imem_addr, 32'h0);
    chk(!dmem_we, "R1 reset write strobe", 32'(dmem_we), 32'h0);
    chk(!dmem_re, "R1 reset read strobe", 32'(dmem_re), 32'h0);

    @(negedge clk);
    rst_n   = 1'b1;
    last_pc = '0;
    cnt     = 1;
    done    = 0;
    cyc     = 0;
    hung    = 1'b0;
    while (done < 700 && !hung) begin
      @(negedge clk);
      cyc++;
      if (imem_addr != last_pc) begin
        ins = imem[last_pc[7:2]];
        tag = tag_of(ins);
        ref_exec(ins, cpi);
        chk(cnt == cpi, {tag, " cycle count"}, 32'(cnt), 32'(cpi));
        chk(imem_addr == ref_pc, (ins[31:26] == OPC_BEQ) ? "R6 branch target" : "R7 next PC",
            imem_addr, ref_pc);
        ref_pc  = imem_addr;
        last_pc = imem_addr;
        cnt     = 1;
        done++;
      end else begin
        cnt++;
        if (cnt > 8 || cyc > 50000) begin
          hung = 1'b1;
          chk(1'b0, "R7 watchdog, PC stuck", 32'(cnt), 32'd5);
        end
      end
      ins = imem[last_pc[7:2]];
      ea  = eff_addr(ins);
      if (dmem_we || dmem_re)
        chk(!(dmem_we && dmem_re), "R10 strobe overlap", {dmem_we, dmem_re}, 32'h0);
      if (dmem_we) begin
        chk(ins[31:26] == OPC_SW && cnt == 4, "R5 store step", 32'(cnt), 32'd4);
        chk(dmem_addr == ea, "R5 store address", dmem_addr, ea);
        chk(dmem_wdata == ref_regs[ins[20:16]],
            (ins[20:16] == 5'd0) ? "R8 zero register store" : "R5 store data",
            dmem_wdata, ref_regs[ins[20:16]]);
      end
      if (dmem_re) begin
        chk(ins[31:26] == OPC_LW && cnt == 4, "R4 load step", 32'(cnt), 32'd4);
        chk(dmem_addr == ea, "R4 load address", dmem_addr, ea);
      end
    end

    for (int i = 0; i < 64; i++)
      chk(dmem[i] == ref_dmem[i], "R5 memory image", dmem[i], ref_dmem[i]);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule